// File: doc/BRIEF.md
# Event Counter with Self-Masking Overflow Interrupt

This block is a single programmable event counter used as a periodic watchdog. Software selects an event and a privilege filter through an event-select register. It then loads the counter with a negative start value and arms a local interrupt vector entry. The counter advances on every clock in which the selected event is present and the current privilege level is enabled. When it wraps from all ones to zero, it raises a one-cycle interrupt request. The vector entry then masks itself.

Software checks for expiry by reading the counter and testing its top implemented bit. While that bit is still 1, the period has not yet elapsed. To take the next expiry, software reloads the counter and rewrites the vector entry as unmasked. A parameter picks the counter write mode. One mode takes 32 bits and sign-extends them from bit 31. The other loads the full implemented width directly.

The vector entry is run by a two-state machine. In state `VEC_MASKED` no request can leave the block. In state `VEC_ARMED` an overflow with interrupt-on-overflow set delivers a request. The transitions are:
- `arm`: a vector write with the mask bit clear, which moves to `VEC_ARMED`.
- `disarm`: a vector write with the mask bit set, which moves to `VEC_MASKED`.
- `deliver`: an overflow delivered in `VEC_ARMED`, which moves to `VEC_MASKED`.

A vector write in the same cycle as `deliver` decides the next state.

Top module: `pmc_watchdog`

## Requirements
- R1: After reset the counter and event-select register read 0, the vector entry reads 0x10000 (masked), and both interrupt outputs are low.
- R2: The event-select register holds enable at bit 22, interrupt-on-overflow at bit 20, kernel-count at bit 17, user-count at bit 16 and an event code in bits 7:0; reads return those bits and zero elsewhere.
- R3: The counter advances only while the enable bit is set; with it clear the count holds.
- R4: An event is counted only when `priv_kernel` is 1 and the kernel-count bit is set, or `priv_kernel` is 0 and the user-count bit is set.
- R5: Codes 0x76 and 0x79 count cycles with `ev_active` high, code 0xC0 counts cycles with `ev_retire` high, and every other code counts nothing.
- R6: With `WRITE_FULL`=0 a counter write loads bits 31:0 and fills all higher counter bits with bit 31; bits 63:32 of the write data are ignored.
- R7: With `WRITE_FULL`=1 a counter write loads bits CTR_W-1:0 of the write data directly.
- R8: A counter read (address 0) returns the counter sign-extended from bit CTR_W-1 to 64 bits; that bit stays 1 until the count wraps.
- R9: A counter write in the same cycle as a counted event loads the written value, with no increment.
- R10: A counted event at all ones wraps the counter to zero; `irq_o` is high for exactly the following cycle when interrupt-on-overflow is set and the entry is armed, and stays low when interrupt-on-overflow is clear.
- R11: The vector entry (address 2) holds a vector in bits 7:0, a delivery mode in bits 10:8 and a mask at bit 16. It sets its mask when it delivers, and later overflows raise nothing until software writes it with bit 16 clear.
- R12: `irq_nmi_o` pulses together with `irq_o` only when the delivery mode field is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 counter, 1 event select, 2 vector entry |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| ev_active | input | 1 | Core is running (not halted) this cycle |
| ev_retire | input | 1 | An instruction retired this cycle |
| irq_o | output | 1 | One-cycle overflow interrupt request |
| irq_nmi_o | output | 1 | Request is in non-maskable delivery mode |

## Verification
All 256 event codes are swept with one fixed mixed pattern of `ev_active` and `ev_retire`. This separates the two cycle codes, the retire code and the codes that count nothing. All eight combinations of privilege level and kernel/user enables, plus a disabled setting, show that the filter picks the right bit. Single-bit write values at each of bits 0 to 31, with junk in the upper write bits, locate the sign-extension boundary. Start values from -1 to -6 check the wrap cycle and the top-bit expiry test cycle by cycle. They are followed by masked, interrupt-disabled and non-NMI-mode overflows, which show which gate stops the request.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_EVSEL  = 2'd1,
        REG_VECTOR = 2'd2
    } reg_sel_e;

    localparam int EVS_EN_BIT   = 22;
    localparam int EVS_INT_BIT  = 20;
    localparam int EVS_KERN_BIT = 17;
    localparam int EVS_USER_BIT = 16;
    localparam int VEC_MASK_BIT = 16;

    localparam logic [7:0] EVC_CYC_A  = 8'h76;
    localparam logic [7:0] EVC_CYC_B  = 8'h79;
    localparam logic [7:0] EVC_RETIRE = 8'hC0;

    localparam logic [2:0] DELIV_NMI = 3'b100;

    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic       kern;
        logic       user;
        logic [7:0] code;
    } evsel_t;

    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] vector;
    } vec_cfg_t;

    typedef enum logic {
        VEC_MASKED = 1'b0,
        VEC_ARMED  = 1'b1
    } vec_state_e;

endpackage

// File: rtl/pmc_evsel.sv
module pmc_evsel
    import pmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wr_word,
    input  logic        priv_kernel,
    input  logic        ev_active,
    input  logic        ev_retire,
    output evsel_t      cfg_o,
    output logic        count_o
);

    evsel_t cfg_q;
    logic   ev_hit;
    logic   priv_ok;
    logic   unused_wr;

    assign unused_wr = ^{wr_word[31:23], wr_word[21], wr_word[19:18], wr_word[15:8]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.en     <= wr_word[EVS_EN_BIT];
            cfg_q.irq_en <= wr_word[EVS_INT_BIT];
            cfg_q.kern   <= wr_word[EVS_KERN_BIT];
            cfg_q.user   <= wr_word[EVS_USER_BIT];
            cfg_q.code   <= wr_word[7:0];
        end
    end

    always_comb begin
        case (cfg_q.code)
            EVC_CYC_A, EVC_CYC_B: ev_hit = ev_active;
            EVC_RETIRE:           ev_hit = ev_retire;
            default:              ev_hit = 1'b0;
        endcase
        priv_ok = priv_kernel ? cfg_q.kern : cfg_q.user;
        count_o = cfg_q.en & priv_ok & ev_hit;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int CTR_W      = 48,
    parameter bit WRITE_FULL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CTR_W-1:0] load_data,
    input  logic             inc,
    output logic [CTR_W-1:0] value_o,
    output logic             wrap_o
);

    localparam int              EXT_W = CTR_W - 32;
    localparam logic [CTR_W-1:0] ONE  = {{(CTR_W-1){1'b0}}, 1'b1};

    logic [CTR_W-1:0] load_val;
    logic [CTR_W-1:0] ctr_q;

    generate
        if (WRITE_FULL) begin : g_full
            assign load_val = load_data;
        end else begin : g_low32
            logic unused_hi;
            assign unused_hi = ^load_data[CTR_W-1:32];
            assign load_val  = {{EXT_W{load_data[31]}}, load_data[31:0]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (load) begin
            ctr_q <= load_val;
        end else if (inc) begin
            ctr_q <= ctr_q + ONE;
        end
    end

    assign wrap_o  = inc & ~load & (&ctr_q);
    assign value_o = ctr_q;

endmodule

// File: rtl/pmc_vec_fsm.sv
module pmc_vec_fsm
    import pmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wr_word,
    input  logic        wrap,
    input  logic        irq_en,
    output logic        masked_o,
    output vec_cfg_t    cfg_o,
    output logic        irq_o,
    output logic        irq_nmi_o
);

    vec_state_e state_q;
    vec_state_e state_d;
    vec_cfg_t   cfg_q;
    logic       deliver;
    logic       irq_q;
    logic       irq_nmi_q;
    logic       unused_wr;

    assign unused_wr = ^{wr_word[31:17], wr_word[15:11]};
    assign deliver   = wrap & irq_en & (state_q == VEC_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VEC_MASKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VEC_ARMED: begin
                if (wr) begin
                    state_d = wr_word[VEC_MASK_BIT] ? VEC_MASKED : VEC_ARMED;
                end else if (deliver) begin
                    state_d = VEC_MASKED;
                end
            end
            VEC_MASKED: begin
                if (wr && !wr_word[VEC_MASK_BIT]) begin
                    state_d = VEC_ARMED;
                end
            end
            default: state_d = VEC_MASKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.mode   <= wr_word[10:8];
            cfg_q.vector <= wr_word[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            irq_nmi_q <= 1'b0;
        end else begin
            irq_q     <= deliver;
            irq_nmi_q <= deliver & (cfg_q.mode == DELIV_NMI);
        end
    end

    assign masked_o  = (state_q == VEC_MASKED);
    assign cfg_o     = cfg_q;
    assign irq_o     = irq_q;
    assign irq_nmi_o = irq_nmi_q;

endmodule

// File: rtl/pmc_watchdog.sv
module pmc_watchdog
    import pmc_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int CTR_W      = 48,
    parameter bit WRITE_FULL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              priv_kernel,
    input  logic              ev_active,
    input  logic              ev_retire,
    output logic              irq_o,
    output logic              irq_nmi_o
);

    localparam int SEXT_W = DATA_W - CTR_W;
    localparam int PAD_W  = DATA_W - 32;

    logic             ctr_wr;
    logic             ev_wr;
    logic             vec_wr;
    logic             count_en;
    logic             ctr_wrap;
    logic             ev_en;
    logic             vec_masked;
    logic [CTR_W-1:0] ctr_q;
    evsel_t           ev_cfg;
    vec_cfg_t         vec_cfg;
    logic [31:0]      ev_word;
    logic [31:0]      vec_word;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign ctr_wr = bus_wr && (bus_addr == REG_COUNT);
    assign ev_wr  = bus_wr && (bus_addr == REG_EVSEL);
    assign vec_wr = bus_wr && (bus_addr == REG_VECTOR);

    pmc_evsel u_evsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ev_wr),
        .wr_word     (bus_wdata[31:0]),
        .priv_kernel (priv_kernel),
        .ev_active   (ev_active),
        .ev_retire   (ev_retire),
        .cfg_o       (ev_cfg),
        .count_o     (count_en)
    );

    pmc_counter #(
        .CTR_W      (CTR_W),
        .WRITE_FULL (WRITE_FULL)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_wr),
        .load_data (bus_wdata[CTR_W-1:0]),
        .inc       (count_en),
        .value_o   (ctr_q),
        .wrap_o    (ctr_wrap)
    );

    pmc_vec_fsm u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (vec_wr),
        .wr_word   (bus_wdata[31:0]),
        .wrap      (ctr_wrap),
        .irq_en    (ev_cfg.irq_en),
        .masked_o  (vec_masked),
        .cfg_o     (vec_cfg),
        .irq_o     (irq_o),
        .irq_nmi_o (irq_nmi_o)
    );

    assign ev_en = ev_cfg.en;

    always_comb begin
        ev_word               = '0;
        ev_word[EVS_EN_BIT]   = ev_cfg.en;
        ev_word[EVS_INT_BIT]  = ev_cfg.irq_en;
        ev_word[EVS_KERN_BIT] = ev_cfg.kern;
        ev_word[EVS_USER_BIT] = ev_cfg.user;
        ev_word[7:0]          = ev_cfg.code;

        vec_word               = '0;
        vec_word[VEC_MASK_BIT] = vec_masked;
        vec_word[10:8]         = vec_cfg.mode;
        vec_word[7:0]          = vec_cfg.vector;
    end

    always_comb begin
        case (bus_addr)
            REG_COUNT:  bus_rdata = {{SEXT_W{ctr_q[CTR_W-1]}}, ctr_q};
            REG_EVSEL:  bus_rdata = {{PAD_W{1'b0}}, ev_word};
            REG_VECTOR: bus_rdata = {{PAD_W{1'b0}}, vec_word};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pmc_watchdog_chk.sv
module pmc_watchdog_chk #(
    parameter int CTR_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             irq_nmi_o,
    input logic             ev_en,
    input logic             ctr_wr,
    input logic             vec_wr,
    input logic             vec_masked,
    input logic [CTR_W-1:0] ctr_val
);

    // R12: the NMI flag never appears without a request
    p_nmi_needs_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi_o |-> irq_o);

    // R10: a request lasts exactly one cycle
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10: a request coincides with the counter sitting at zero
    p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctr_val == '0));

    // R11: delivery leaves the entry masked unless software rewrote it then
    p_masked_after_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !$past(vec_wr)) |-> vec_masked);

    // R11: a masked entry lets nothing out on the next cycle
    p_masked_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_masked |=> !irq_o);

    // R3: with enable clear and no write the count holds
    p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_en && !ctr_wr) |=> $stable(ctr_val));

endmodule

bind pmc_watchdog pmc_watchdog_chk #(.CTR_W(CTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .irq_nmi_o  (irq_nmi_o),
    .ev_en      (ev_en),
    .ctr_wr     (ctr_wr),
    .vec_wr     (vec_wr),
    .vec_masked (vec_masked),
    .ctr_val    (ctr_q)
);

// File: tb/pmc_watchdog_test.sv
`timescale 1ns/1ps
module pmc_watchdog_test;

    localparam logic [1:0] A_CNT = 2'd0;
    localparam logic [1:0] A_EVS = 2'd1;
    localparam logic [1:0] A_VEC = 2'd2;
    localparam logic [63:0] B_EN   = 64'h40_0000;
    localparam logic [63:0] B_INT  = 64'h10_0000;
    localparam logic [63:0] B_KERN = 64'h02_0000;
    localparam logic [63:0] B_USER = 64'h01_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [63:0] full_rdata;
    logic        priv_kernel = 1'b1;
    logic        ev_active = 1'b0;
    logic        ev_retire = 1'b0;
    logic        irq_o, irq_nmi_o, full_irq, full_nmi;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pmc_watchdog uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .priv_kernel(priv_kernel),
        .ev_active(ev_active), .ev_retire(ev_retire), .irq_o(irq_o), .irq_nmi_o(irq_nmi_o)
    );

    pmc_watchdog #(.WRITE_FULL(1'b1)) uut_full (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(full_rdata), .priv_kernel(priv_kernel),
        .ev_active(ev_active), .ev_retire(ev_retire), .irq_o(full_irq), .irq_nmi_o(full_nmi)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input logic act, input logic ret, input int n);
        for (int i = 0; i < n; i++) begin
            ev_active = act; ev_retire = ret;
            @(negedge clk);
        end
        ev_active = 1'b0; ev_retire = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, exp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CNT, d); check("R1 counter", d, 64'h0);
        rd(A_EVS, d); check("R1 evsel", d, 64'h0);
        rd(A_VEC, d); check("R1 vector", d, 64'h1_0000);
        check("R1 irq", {62'h0, irq_o, irq_nmi_o}, 64'h0);

        // R2 readback of implemented fields only
        wr(A_EVS, '1);
        rd(A_EVS, d); check("R2 evsel readback", d, 64'h53_00FF);
        wr(A_VEC, '1);
        rd(A_VEC, d); check("R11 vector readback", d, 64'h1_07FF);

        // R5 sweep of every event code
        priv_kernel = 1'b1;
        for (int c = 0; c < 256; c++) begin
            wr(A_EVS, B_EN | B_KERN | B_USER | 64'(c));
            wr(A_CNT, 64'h0);
            run(1'b1, 1'b0, 5);
            run(1'b0, 1'b1, 3);
            run(1'b1, 1'b1, 2);
            if (c == 'h76 || c == 'h79) exp = 64'd7;
            else if (c == 'hC0)        exp = 64'd5;
            else                       exp = 64'd0;
            rd(A_CNT, d); check($sformatf("R5 code %02h", c), d, exp);
        end

        // R4 privilege filter sweep, R3 enable gating
        for (int k = 0; k < 2; k++) begin
            for (int m = 0; m < 4; m++) begin
                priv_kernel = k[0];
                wr(A_EVS, B_EN | (m[1] ? B_KERN : 64'h0) | (m[0] ? B_USER : 64'h0) | 64'h76);
                wr(A_CNT, 64'h0);
                run(1'b1, 1'b0, 4);
                exp = ((k == 1) ? m[1] : m[0]) ? 64'd4 : 64'd0;
                rd(A_CNT, d); check($sformatf("R4 priv %0d mode %0d", k, m), d, exp);
            end
        end
        priv_kernel = 1'b1;
        wr(A_EVS, B_KERN | B_USER | 64'h76);
        wr(A_CNT, 64'h10);
        run(1'b1, 1'b1, 6);
        rd(A_CNT, d); check("R3 enable clear holds", d, 64'h10);
        wr(A_EVS, 64'h0);
        run(1'b1, 1'b0, 3);
        rd(A_CNT, d); check("R3 cleared evsel holds", d, 64'h10);

        // R6 sign extension boundary sweep, R8 read extension
        for (int i = 0; i < 32; i++) begin
            wr(A_CNT, 64'hDEAD_BEEF_0000_0000 | (64'h1 << i));
            exp = (i == 31) ? 64'hFFFF_FFFF_8000_0000 : (64'h1 << i);
            rd(A_CNT, d); check($sformatf("R6 bit %0d", i), d, exp);
            check($sformatf("R8 top bit %0d", i), {63'h0, d[47]}, {63'h0, i == 31});
        end

        // R7 full-width write variant
        wr(A_CNT, 64'hCAFE_1234_8000_0001);
        bus_addr = A_CNT; #1;
        check("R7 full positive", full_rdata, 64'h0000_1234_8000_0001);
        wr(A_CNT, 64'h0000_8000_0000_0005);
        bus_addr = A_CNT; #1;
        check("R7 full negative", full_rdata, 64'hFFFF_8000_0000_0005);

        // R9 write beats a counted event in the same cycle
        wr(A_EVS, B_EN | B_KERN | B_USER | 64'h76);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 64'd100; ev_active = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_active = 1'b0;
        rd(A_CNT, d); check("R9 write priority", d, 64'd100);

        // R10/R8/R12 overflow sweep over start values -1..-6
        wr(A_EVS, B_EN | B_INT | B_KERN | B_USER | 64'h76);
        for (int n = 1; n <= 6; n++) begin
            wr(A_VEC, 64'h400);
            wr(A_CNT, 64'(32'(-n)));
            for (int c = 1; c <= n; c++) begin
                ev_active = 1'b1;
                @(negedge clk);
                ev_active = 1'b0;
                check($sformatf("R10 irq n%0d c%0d", n, c), {63'h0, irq_o}, {63'h0, c == n});
                check($sformatf("R12 nmi n%0d c%0d", n, c), {63'h0, irq_nmi_o}, {63'h0, c == n});
                rd(A_CNT, d);
                check($sformatf("R8 expiry bit n%0d c%0d", n, c), {63'h0, d[47]}, {63'h0, c < n});
            end
            rd(A_CNT, d); check($sformatf("R10 wrap zero n%0d", n), d, 64'h0);
            @(negedge clk);
            check($sformatf("R10 pulse ends n%0d", n), {63'h0, irq_o}, 64'h0);
            rd(A_VEC, d); check($sformatf("R11 auto mask n%0d", n), d, 64'h1_0400);
        end

        // R11 masked entry blocks a second overflow
        wr(A_CNT, 64'hFFFF_FFFE);
        for (int c = 0; c < 2; c++) begin
            ev_active = 1'b1; @(negedge clk); ev_active = 1'b0;
            check("R11 masked no irq", {63'h0, irq_o}, 64'h0);
        end
        rd(A_CNT, d); check("R11 masked still wraps", d, 64'h0);
        wr(A_VEC, 64'h400);
        wr(A_CNT, 64'hFFFF_FFFF);
        ev_active = 1'b1; @(negedge clk); ev_active = 1'b0;
        check("R11 rearmed irq", {63'h0, irq_o}, 64'h1);

        // R10 interrupt-on-overflow clear
        wr(A_VEC, 64'h400);
        wr(A_EVS, B_EN | B_KERN | B_USER | 64'h76);
        wr(A_CNT, 64'hFFFF_FFFF);
        ev_active = 1'b1; @(negedge clk); ev_active = 1'b0;
        check("R10 int clear no irq", {63'h0, irq_o}, 64'h0);
        rd(A_VEC, d); check("R10 int clear stays armed", d, 64'h400);

        // R12 non-NMI delivery mode
        wr(A_EVS, B_EN | B_INT | B_KERN | B_USER | 64'h79);
        wr(A_VEC, 64'h021);
        wr(A_CNT, 64'hFFFF_FFFF);
        ev_active = 1'b1; @(negedge clk); ev_active = 1'b0;
        check("R12 fixed mode irq", {62'h0, irq_o, irq_nmi_o}, 64'h2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule